// File: doc/BRIEF.md
# Status-Word Swap Interrupt Controller

This block owns the processor status word: a privileged-mode flag, a program counter, a condition code, a cause code and a pair of address bounds. Every memory access the processor presents is compared against the bounds, and an address outside them becomes a program exception. Program exceptions, I/O-completion events and timer events are captured as pending requests and arbitrated by class.

Accepting a request runs a three-cycle status-word exchange. The cause code is written into the live word. The complete word is then copied into that class's save slot. Finally, a full replacement word taken from that class's vector is installed. Each vector carries its service-routine address, sets the privileged flag and opens the bounds to the whole address space. A return request issued in privileged mode copies a chosen save slot back into the live word. The processor updates the program counter and condition code through write strobes, and it changes the bounds through a write that only privileged code may perform.

Top module: `psw_swap_unit`

## Requirements
- R1: After reset the live word is privileged (`psw_priv`=1), with `psw_pc`=RESET_PC, `psw_cc`=0, `psw_ic`=0, `psw_lo`=0, `psw_hi`=all ones, and `swap_busy`=0. Every save slot starts as a user-mode word (privileged flag 0, pc RESET_PC, cc 0, cause 0, lo 0, hi all ones).
- R2: `acc_fault` is 1 in the same cycle that `mem_req` is 1 and `mem_addr` is below `psw_lo` or above `psw_hi`. Both bounds are inclusive. A fault that is present at a clock edge raises a program request with cause 3.
- R3: Cause codes are 3-bit: 1 overflow, 2 addressing exception, 3 protection exception, 4 software interrupt, 5 I/O complete, 6 timer, 0 none.
- R4: A request that is pending while the unit is idle is accepted at the next edge. That edge writes the cause into `psw_ic` and raises `swap_busy`. `swap_busy` stays high for exactly two cycles. The edge that lowers it installs the vector word.
- R5: The second edge of the exchange stores the entire live word, including the new cause, into the slot of the accepted class: 0 for program, 1 for I/O, 2 for timer.
- R6: The installed vector word has privileged flag 1, pc equal to the class's vector parameter (VEC_PROG, VEC_IO or VEC_TMR), cc 0, cause 0, lo 0 and hi all ones.
- R7: Class priority is program, then timer, then I/O. A class that loses the arbitration stays pending and is accepted after the exchanges ahead of it, back to back.
- R8: When several program causes arrive in the same cycle, the lowest cause code is recorded. A program cause that arrives while another program cause is already pending and not yet accepted is discarded.
- R9: Events that arrive while an exchange is running are latched and accepted only after that exchange ends.
- R10: When idle, `rti` with `psw_priv`=1 and `rti_cls` in 0..2 restores the live word from that slot at the next edge. In the same cycle it takes precedence over acceptance of a pending request. In user mode, or with `rti_cls`=3, `rti` has no effect.
- R11: When idle and privileged, `bnd_we` loads `psw_lo`/`psw_hi` from `lo_in`/`hi_in`. In user mode the write leaves the bounds unchanged and raises a program request with cause 2.
- R12: `pc_we`/`cc_we` (and `bnd_we`) are honoured only when the unit is idle and neither accepts a request nor performs a return at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_req | input | 1 | Memory access present this cycle |
| mem_addr | input | AW | Address of the access |
| ovf_evt | input | 1 | Arithmetic overflow event |
| adrx_evt | input | 1 | Addressing exception event |
| swi_evt | input | 1 | Software interrupt instruction executed |
| io_evt | input | 1 | I/O completion event |
| tmr_evt | input | 1 | Timer interval elapsed |
| pc_we | input | 1 | Program counter write strobe |
| pc_in | input | AW | New program counter |
| cc_we | input | 1 | Condition code write strobe |
| cc_in | input | CCW | New condition code |
| bnd_we | input | 1 | Bound register write strobe |
| lo_in | input | AW | New lower bound |
| hi_in | input | AW | New upper bound |
| rti | input | 1 | Return-from-interrupt request |
| rti_cls | input | 2 | Save slot to restore from |
| psw_priv | output | 1 | Privileged-mode flag |
| psw_pc | output | AW | Program counter |
| psw_cc | output | CCW | Condition code |
| psw_ic | output | 3 | Cause code field |
| psw_lo | output | AW | Lower bound (first allowed byte) |
| psw_hi | output | AW | Upper bound (last allowed byte) |
| swap_busy | output | 1 | Exchange in progress |
| acc_fault | output | 1 | Current access is out of bounds |

## Verification
The bound checker asserts properties on every cycle. Each exchange must keep the busy flag high for exactly two cycles, must show a valid cause code while it runs, and must not change the program counter during the save cycle. Privilege may rise only from a vector load, and every vector load must leave a privileged word with wide bounds. A user-mode bound write must leave the bounds untouched. The bench's scenarios carry the rest of the evidence. Only those scenarios can show which class wins a three-way race, that losers are served back to back, that a second program cause is dropped while a first waits, that a return beats a pending request, and that a restored word matches the one saved, including its cause code.

// File: rtl/psw_pkg.sv
package psw_pkg;

   localparam logic [2:0] CAUSE_NONE = 3'd0;
   localparam logic [2:0] CAUSE_OVF  = 3'd1;
   localparam logic [2:0] CAUSE_ADRX = 3'd2;
   localparam logic [2:0] CAUSE_PROT = 3'd3;
   localparam logic [2:0] CAUSE_SWI  = 3'd4;
   localparam logic [2:0] CAUSE_IO   = 3'd5;
   localparam logic [2:0] CAUSE_TMR  = 3'd6;

   localparam int unsigned NUM_CLS = 3;
   localparam logic [1:0] CLS_PROG = 2'd0;
   localparam logic [1:0] CLS_IO   = 2'd1;
   localparam logic [1:0] CLS_TMR  = 2'd2;

   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_SAVE = 2'd1,
      PH_LOAD = 2'd2
   } phase_e;

endpackage

// File: rtl/psw_bound_chk.sv
module psw_bound_chk #(
   parameter int unsigned AW = 16
) (
   input  logic          req,
   input  logic [AW-1:0] addr,
   input  logic [AW-1:0] lo,
   input  logic [AW-1:0] hi,
   output logic          fault
);
   logic below, above;

   always_comb begin
      below = addr < lo;
      above = addr > hi;
      fault = req & (below | above);
   end
endmodule

// File: rtl/psw_event_arb.sv
module psw_event_arb
   import psw_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ovf,
   input  logic       adrx,
   input  logic       prot,
   input  logic       swi,
   input  logic       io,
   input  logic       tmr,
   input  logic       ack,
   output logic       req_any,
   output logic [1:0] sel_cls,
   output logic [2:0] sel_code
);
   logic [2:0] prog_q;
   logic       io_q, tmr_q;
   logic [2:0] cand;
   logic       ack_prog, ack_io, ack_tmr;

   // lowest code wins among same-cycle program causes
   always_comb begin
      if (ovf)       cand = CAUSE_OVF;
      else if (adrx) cand = CAUSE_ADRX;
      else if (prot) cand = CAUSE_PROT;
      else if (swi)  cand = CAUSE_SWI;
      else           cand = CAUSE_NONE;
   end

   always_comb begin
      if (prog_q != CAUSE_NONE) begin
         sel_cls  = CLS_PROG;
         sel_code = prog_q;
      end else if (tmr_q) begin
         sel_cls  = CLS_TMR;
         sel_code = CAUSE_TMR;
      end else begin
         sel_cls  = CLS_IO;
         sel_code = CAUSE_IO;
      end
      req_any  = (prog_q != CAUSE_NONE) | io_q | tmr_q;
      ack_prog = ack & (sel_cls == CLS_PROG);
      ack_io   = ack & (sel_cls == CLS_IO);
      ack_tmr  = ack & (sel_cls == CLS_TMR);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prog_q <= CAUSE_NONE;
         io_q   <= 1'b0;
         tmr_q  <= 1'b0;
      end else begin
         if (ack_prog || prog_q == CAUSE_NONE) prog_q <= cand;
         io_q  <= io  | (io_q  & ~ack_io);
         tmr_q <= tmr | (tmr_q & ~ack_tmr);
      end
   end
endmodule

// File: rtl/psw_save_bank.sv
module psw_save_bank #(
   parameter int unsigned   WW    = 8,
   parameter int unsigned   NSLOT = 3,
   parameter int unsigned   SW    = (NSLOT > 1) ? $clog2(NSLOT) : 1,
   parameter logic [WW-1:0] INIT  = '0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [SW-1:0] wsel,
   input  logic [WW-1:0] wdata,
   input  logic [SW-1:0] rsel,
   output logic [WW-1:0] rdata
);
   logic [WW-1:0] slot_q [NSLOT];

   for (genvar g = 0; g < NSLOT; g++) begin : g_slot
      always_ff @(posedge clk) begin
         if (!rst_n)                         slot_q[g] <= INIT;
         else if (we && wsel == SW'(g))      slot_q[g] <= wdata;
      end
   end

   always_comb begin
      rdata = INIT;
      for (int i = 0; i < NSLOT; i++)
         if (rsel == SW'(i)) rdata = slot_q[i];
   end
endmodule

// File: rtl/psw_swap_unit.sv
module psw_swap_unit
   import psw_pkg::*;
#(
   parameter int unsigned AW       = 16,
   parameter int unsigned CCW      = 2,
   parameter int unsigned RESET_PC = 'h0040,
   parameter int unsigned VEC_PROG = 'h0100,
   parameter int unsigned VEC_IO   = 'h0200,
   parameter int unsigned VEC_TMR  = 'h0300
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           mem_req,
   input  logic [AW-1:0]  mem_addr,
   input  logic           ovf_evt,
   input  logic           adrx_evt,
   input  logic           swi_evt,
   input  logic           io_evt,
   input  logic           tmr_evt,
   input  logic           pc_we,
   input  logic [AW-1:0]  pc_in,
   input  logic           cc_we,
   input  logic [CCW-1:0] cc_in,
   input  logic           bnd_we,
   input  logic [AW-1:0]  lo_in,
   input  logic [AW-1:0]  hi_in,
   input  logic           rti,
   input  logic [1:0]     rti_cls,
   output logic           psw_priv,
   output logic [AW-1:0]  psw_pc,
   output logic [CCW-1:0] psw_cc,
   output logic [2:0]     psw_ic,
   output logic [AW-1:0]  psw_lo,
   output logic [AW-1:0]  psw_hi,
   output logic           swap_busy,
   output logic           acc_fault
);
   localparam int unsigned PW = 1 + CCW + 3 + 3 * AW;
   localparam logic [PW-1:0] USER_INIT =
      {1'b0, {CCW{1'b0}}, CAUSE_NONE, AW'(RESET_PC), {AW{1'b0}}, {AW{1'b1}}};
   localparam logic [AW-1:0] VPC [NUM_CLS] = '{AW'(VEC_PROG), AW'(VEC_IO), AW'(VEC_TMR)};

   // elaboration-time parameter checks
   if (AW < 4 || AW > 24) begin : g_bad_aw
      $error("psw_swap_unit: AW must lie in 4..24");
   end
   if (CCW < 1 || CCW > 8) begin : g_bad_ccw
      $error("psw_swap_unit: CCW must lie in 1..8");
   end
   if ((RESET_PC >> AW) != 0 || (VEC_PROG >> AW) != 0 ||
       (VEC_IO >> AW) != 0 || (VEC_TMR >> AW) != 0) begin : g_bad_vec
      $error("psw_swap_unit: reset or vector address exceeds AW bits");
   end

   logic           priv_q;
   logic [AW-1:0]  pc_q, lo_q, hi_q;
   logic [CCW-1:0] cc_q;
   logic [2:0]     ic_q;
   phase_e         ph_q;
   logic [1:0]     cls_q;

   logic [PW-1:0]  cur_word, sv_rd;
   logic [PW-1:0]  vec_tbl [NUM_CLS];
   logic           idle, rti_ok, take, upd_ok, bnd_bad;
   logic           req_any;
   logic [1:0]     sel_cls;
   logic [2:0]     sel_code;

   for (genvar g = 0; g < NUM_CLS; g++) begin : g_vec
      assign vec_tbl[g] = {1'b1, {CCW{1'b0}}, CAUSE_NONE, VPC[g], {AW{1'b0}}, {AW{1'b1}}};
   end

   assign cur_word = {priv_q, cc_q, ic_q, pc_q, lo_q, hi_q};
   assign idle     = (ph_q == PH_IDLE);
   assign rti_ok   = idle & rti & priv_q & (rti_cls != 2'd3);
   assign take     = idle & req_any & ~rti_ok;
   assign upd_ok   = idle & ~take & ~rti_ok;
   assign bnd_bad  = upd_ok & bnd_we & ~priv_q;

   psw_bound_chk #(.AW(AW)) u_bound (
      .req   (mem_req),
      .addr  (mem_addr),
      .lo    (lo_q),
      .hi    (hi_q),
      .fault (acc_fault)
   );

   psw_event_arb u_arb (
      .clk      (clk),
      .rst_n    (rst_n),
      .ovf      (ovf_evt),
      .adrx     (adrx_evt | bnd_bad),
      .prot     (acc_fault),
      .swi      (swi_evt),
      .io       (io_evt),
      .tmr      (tmr_evt),
      .ack      (take),
      .req_any  (req_any),
      .sel_cls  (sel_cls),
      .sel_code (sel_code)
   );

   psw_save_bank #(.WW(PW), .NSLOT(NUM_CLS), .SW(2), .INIT(USER_INIT)) u_bank (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (ph_q == PH_SAVE),
      .wsel  (cls_q),
      .wdata (cur_word),
      .rsel  (rti_cls),
      .rdata (sv_rd)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         priv_q <= 1'b1;
         pc_q   <= AW'(RESET_PC);
         cc_q   <= '0;
         ic_q   <= CAUSE_NONE;
         lo_q   <= '0;
         hi_q   <= '1;
         ph_q   <= PH_IDLE;
         cls_q  <= CLS_PROG;
      end else begin
         case (ph_q)
            PH_IDLE: begin
               if (rti_ok) begin
                  {priv_q, cc_q, ic_q, pc_q, lo_q, hi_q} <= sv_rd;
               end else if (take) begin
                  ic_q  <= sel_code;
                  cls_q <= sel_cls;
                  ph_q  <= PH_SAVE;
               end else begin
                  if (pc_we) pc_q <= pc_in;
                  if (cc_we) cc_q <= cc_in;
                  if (bnd_we && priv_q) begin
                     lo_q <= lo_in;
                     hi_q <= hi_in;
                  end
               end
            end
            PH_SAVE: ph_q <= PH_LOAD;
            PH_LOAD: begin
               {priv_q, cc_q, ic_q, pc_q, lo_q, hi_q} <= vec_tbl[cls_q];
               ph_q <= PH_IDLE;
            end
            default: ph_q <= PH_IDLE;
         endcase
      end
   end

   assign psw_priv  = priv_q;
   assign psw_pc    = pc_q;
   assign psw_cc    = cc_q;
   assign psw_ic    = ic_q;
   assign psw_lo    = lo_q;
   assign psw_hi    = hi_q;
   assign swap_busy = ~idle;
endmodule

// File: rtl/psw_swap_chk.sv
module psw_swap_chk #(
   parameter int unsigned AW = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic          swap_busy,
   input logic          psw_priv,
   input logic [AW-1:0] psw_pc,
   input logic [AW-1:0] psw_lo,
   input logic [AW-1:0] psw_hi,
   input logic [2:0]    psw_ic,
   input logic          bnd_we
);
   // R4
   seq_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(swap_busy) |=> swap_busy ##1 !swap_busy);

   // R3
   cause_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(swap_busy) |-> (psw_ic != 3'd0 && psw_ic <= 3'd6));

   // R6
   vec_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(swap_busy) |-> (psw_priv && psw_lo == '0 && psw_hi == '1 && psw_ic == 3'd0));

   // R11
   user_bnd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!swap_busy && !psw_priv && bnd_we) |=> ($stable(psw_lo) && $stable(psw_hi)));

   // R10
   priv_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(psw_priv) |-> $past(swap_busy));

   // R12
   save_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(swap_busy) |=> $stable(psw_pc));
endmodule

bind psw_swap_unit psw_swap_chk #(.AW(AW)) u_swap_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .swap_busy (swap_busy),
   .psw_priv  (psw_priv),
   .psw_pc    (psw_pc),
   .psw_lo    (psw_lo),
   .psw_hi    (psw_hi),
   .psw_ic    (psw_ic),
   .bnd_we    (bnd_we)
);

// File: tb/test_psw_swap_unit.sv
`timescale 1ns/1ps
module test_psw_swap_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        mem_req = 0, ovf_evt = 0, adrx_evt = 0, swi_evt = 0, io_evt = 0, tmr_evt = 0;
   logic [15:0] mem_addr = 0, pc_in = 0, lo_in = 0, hi_in = 0;
   logic        pc_we = 0, cc_we = 0, bnd_we = 0, rti = 0;
   logic [1:0]  cc_in = 0, rti_cls = 0;
   logic        psw_priv, swap_busy, acc_fault;
   logic [15:0] psw_pc, psw_lo, psw_hi;
   logic [1:0]  psw_cc;
   logic [2:0]  psw_ic;

   int checks = 0, errors = 0;
   bit done = 0;

   always #2 clk = ~clk;

   psw_swap_unit i_psw_swap_unit (
      .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_addr(mem_addr),
      .ovf_evt(ovf_evt), .adrx_evt(adrx_evt), .swi_evt(swi_evt), .io_evt(io_evt), .tmr_evt(tmr_evt),
      .pc_we(pc_we), .pc_in(pc_in), .cc_we(cc_we), .cc_in(cc_in),
      .bnd_we(bnd_we), .lo_in(lo_in), .hi_in(hi_in), .rti(rti), .rti_cls(rti_cls),
      .psw_priv(psw_priv), .psw_pc(psw_pc), .psw_cc(psw_cc), .psw_ic(psw_ic),
      .psw_lo(psw_lo), .psw_hi(psw_hi), .swap_busy(swap_busy), .acc_fault(acc_fault)
   );

   task automatic chk(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual %0h expected %0h at %0t", tag, act, exp, $time);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   int m_priv, m_pc, m_cc, m_ic, m_lo, m_hi, m_ph, m_cls, m_prog;
   bit m_io, m_tm;
   int s_priv[3], s_pc[3], s_cc[3], s_ic[3], s_lo[3], s_hi[3];
   int vec_pc[3] = '{'h100, 'h200, 'h300};
   bit idle_m, pend_m, rti_m, take_m, upd_m;
   int tcls, tcode, cand;

   function automatic bit m_fault();
      return mem_req && (int'(mem_addr) < m_lo || int'(mem_addr) > m_hi);
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_priv = 1; m_pc = 'h40; m_cc = 0; m_ic = 0; m_lo = 0; m_hi = 'hFFFF;
         m_ph = 0; m_cls = 0; m_prog = 0; m_io = 0; m_tm = 0;
         for (int k = 0; k < 3; k++) begin
            s_priv[k] = 0; s_pc[k] = 'h40; s_cc[k] = 0; s_ic[k] = 0; s_lo[k] = 0; s_hi[k] = 'hFFFF;
         end
      end else begin
         idle_m = (m_ph == 0);
         pend_m = (m_prog != 0) || m_io || m_tm;
         rti_m  = idle_m && rti && m_priv == 1 && rti_cls != 3;
         take_m = idle_m && pend_m && !rti_m;
         upd_m  = idle_m && !take_m && !rti_m;
         tcls   = (m_prog != 0) ? 0 : (m_tm ? 2 : 1);
         tcode  = (m_prog != 0) ? m_prog : (m_tm ? 6 : 5);
         if (ovf_evt) cand = 1;
         else if (adrx_evt || (upd_m && bnd_we && m_priv == 0)) cand = 2;
         else if (m_fault()) cand = 3;
         else if (swi_evt) cand = 4;
         else cand = 0;
         if ((take_m && tcls == 0) || m_prog == 0) m_prog = cand;
         m_io = io_evt || (m_io && !(take_m && tcls == 1));
         m_tm = tmr_evt || (m_tm && !(take_m && tcls == 2));
         case (m_ph)
            0: begin
               if (rti_m) begin
                  m_priv = s_priv[rti_cls]; m_pc = s_pc[rti_cls]; m_cc = s_cc[rti_cls];
                  m_ic = s_ic[rti_cls]; m_lo = s_lo[rti_cls]; m_hi = s_hi[rti_cls];
               end else if (take_m) begin
                  m_ic = tcode; m_cls = tcls; m_ph = 1;
               end else begin
                  if (pc_we) m_pc = int'(pc_in);
                  if (cc_we) m_cc = int'(cc_in);
                  if (bnd_we && m_priv == 1) begin m_lo = int'(lo_in); m_hi = int'(hi_in); end
               end
            end
            1: begin
               s_priv[m_cls] = m_priv; s_pc[m_cls] = m_pc; s_cc[m_cls] = m_cc;
               s_ic[m_cls] = m_ic; s_lo[m_cls] = m_lo; s_hi[m_cls] = m_hi;
               m_ph = 2;
            end
            default: begin
               m_priv = 1; m_pc = vec_pc[m_cls]; m_cc = 0; m_ic = 0; m_lo = 0; m_hi = 'hFFFF;
               m_ph = 0;
            end
         endcase
      end
   end

   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk("R4 model busy", int'(swap_busy), int'(m_ph != 0));
         chk("R10 model priv", int'(psw_priv), m_priv);
         chk("R12 model pc", int'(psw_pc), m_pc);
         chk("R12 model cc", int'(psw_cc), m_cc);
         chk("R3 model cause", int'(psw_ic), m_ic);
         chk("R11 model lo", int'(psw_lo), m_lo);
         chk("R11 model hi", int'(psw_hi), m_hi);
         chk("R2 model fault", int'(acc_fault), int'(m_fault()));
      end
   end

   task automatic step();
      @(posedge clk);
      #0.2;
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [15:0] pc_keep;
      repeat (3) step();
      // R1 reset state
      chk("R1 priv", psw_priv, 1); chk("R1 pc", psw_pc, 'h40); chk("R1 cc", psw_cc, 0);
      chk("R1 ic", psw_ic, 0); chk("R1 lo", psw_lo, 0); chk("R1 hi", psw_hi, 'hFFFF);
      chk("R1 busy", swap_busy, 0);
      rst_n = 1;
      step();
      // R12 datapath writes while idle
      pc_we = 1; pc_in = 'h1234; cc_we = 1; cc_in = 2;
      step(); pc_we = 0; cc_we = 0;
      chk("R12 pc write", psw_pc, 'h1234); chk("R12 cc write", psw_cc, 2);
      // R11 privileged bound write
      bnd_we = 1; lo_in = 'h1000; hi_in = 'h1FFF;
      step(); bnd_we = 0;
      chk("R11 lo write", psw_lo, 'h1000); chk("R11 hi write", psw_hi, 'h1FFF);
      // R2 inclusive bounds
      mem_req = 1; mem_addr = 'h1000; #0.1 chk("R2 at lo", acc_fault, 0);
      mem_addr = 'h1FFF; #0.1 chk("R2 at hi", acc_fault, 0);
      mem_addr = 'h0FFF; #0.1 chk("R2 below", acc_fault, 1);
      mem_addr = 'h2000; #0.1 chk("R2 above", acc_fault, 1);
      step(); mem_req = 0;
      step();
      chk("R4 busy after accept", swap_busy, 1); chk("R2 protection cause", psw_ic, 3);
      step(); chk("R4 busy second cycle", swap_busy, 1);
      step();
      chk("R4 busy ends", swap_busy, 0); chk("R6 priv", psw_priv, 1); chk("R6 pc", psw_pc, 'h100);
      chk("R6 lo", psw_lo, 0); chk("R6 hi", psw_hi, 'hFFFF); chk("R6 cc", psw_cc, 0);
      // R5 restore shows the saved word
      rti = 1; rti_cls = 0;
      step(); rti = 0;
      chk("R5 priv", psw_priv, 1); chk("R5 pc", psw_pc, 'h1234); chk("R5 cc", psw_cc, 2);
      chk("R5 ic", psw_ic, 3); chk("R5 lo", psw_lo, 'h1000); chk("R5 hi", psw_hi, 'h1FFF);
      // R10 enter user mode from untouched timer slot
      rti = 1; rti_cls = 2;
      step(); rti = 0;
      chk("R10 user priv", psw_priv, 0); chk("R10 user pc", psw_pc, 'h40);
      chk("R10 user lo", psw_lo, 0); chk("R10 user hi", psw_hi, 'hFFFF);
      // R10 rti ignored in user mode
      rti = 1; rti_cls = 0;
      step(); rti = 0;
      chk("R10 ignored priv", psw_priv, 0); chk("R10 ignored pc", psw_pc, 'h40);
      // R11 user bound write ignored and raises cause 2
      bnd_we = 1; lo_in = 5; hi_in = 6;
      step(); bnd_we = 0;
      chk("R11 user lo kept", psw_lo, 0); chk("R11 user hi kept", psw_hi, 'hFFFF);
      step(); chk("R11 cause", psw_ic, 2); chk("R11 busy", swap_busy, 1);
      step(); step();
      chk("R6 priv from user", psw_priv, 1); chk("R6 prog vector", psw_pc, 'h100);
      // R10 return beats a pending request
      tmr_evt = 1;
      step(); tmr_evt = 0; rti = 1; rti_cls = 0;
      step(); rti = 0;
      chk("R10 precedence priv", psw_priv, 0); chk("R10 precedence busy", swap_busy, 0);
      chk("R10 precedence ic", psw_ic, 2);
      step(); chk("R9 timer accepted", swap_busy, 1); chk("R3 timer cause", psw_ic, 6);
      step(); step(); chk("R6 timer vector", psw_pc, 'h300); chk("R6 timer priv", psw_priv, 1);
      // R7 three-way race
      io_evt = 1; tmr_evt = 1; ovf_evt = 1;
      step(); io_evt = 0; tmr_evt = 0; ovf_evt = 0;
      step(); chk("R7 program first", psw_ic, 1);
      pc_keep = psw_pc; pc_we = 1; pc_in = 'hBEEF;
      step(); pc_we = 0;
      chk("R12 pc write ignored while busy", psw_pc, pc_keep);
      step(); chk("R7 prog vector", psw_pc, 'h100); chk("R7 idle gap", swap_busy, 0);
      step(); chk("R7 timer second", psw_ic, 6); chk("R7 timer busy", swap_busy, 1);
      step(); step(); chk("R7 timer vector", psw_pc, 'h300);
      step(); chk("R7 io third", psw_ic, 5);
      step(); step(); chk("R7 io vector", psw_pc, 'h200); chk("R7 all served", swap_busy, 0);
      // R8 / R9 program causes during an exchange
      io_evt = 1;
      step(); io_evt = 0;
      step(); swi_evt = 1;
      step(); swi_evt = 0; ovf_evt = 1;
      step(); ovf_evt = 0;
      chk("R9 exchange done", swap_busy, 0);
      step(); chk("R9 held cause accepted", swap_busy, 1); chk("R8 first program cause kept", psw_ic, 4);
      step(); step(); step();
      chk("R8 dropped cause not served", swap_busy, 0);
      // R8 same-cycle program causes
      adrx_evt = 1; swi_evt = 1;
      step(); adrx_evt = 0; swi_evt = 0;
      step(); chk("R8 lowest code", psw_ic, 2);
      step(); step(); step(); step();
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule